// File: doc/BRIEF.md
# Wide Instruction Prefetch Buffer

This block sits between the instruction fetch port of a fast 32-bit core and a slow flash built from six 32-bit banks. One flash read takes six core cycles. Without help, every fetch would therefore stall for five wait states. On a reload, the block drives six consecutive word addresses, one per bank, and reads all six banks in one slow access. It keeps the 192-bit result and then hands out the following sequential words with no wait states.

The core holds a request and its byte address until the wait signal drops. The fetched word is valid in the cycle in which wait is low. The block tracks which word the core should ask for next:
- A request for that word is a hit.
- Any other address is treated as a branch, which discards the buffer and starts a reload.

Once the last buffered word has been handed out, the block starts loading the next group on its own in the following cycle. An enable input turns the buffering off, so that every fetch then goes straight to flash.

Top module: `ifetch_prefetch_buf`

## Requirements
- R1: After reset the buffer holds nothing valid, `fetch_wait` and `flash_rd` are low, and the first fetch always triggers a reload with five wait states.
- R2: A fetch that misses holds `fetch_wait` high for exactly five cycles. The requested word appears on `fetch_data` in the cycle in which `fetch_wait` drops.
- R3: A reload reads the six-word group aligned to a multiple of six words (24 bytes) that contains the requested word. Bank slot i of `flash_addr` (bits i*18 upward) carries base+i, and slot i of `flash_rdata` (bits i*32 upward) returns that word. `flash_rd` stays high with unchanged addresses for six cycles.
- R4: The word address is `fetch_addr[19:2]`, and bits [1:0] are ignored. Each following sequential word left in the buffer is returned with zero wait states.
- R5: In the cycle after the sixth word of a group is handed out, a reload of the next group starts without any request. A fetch of that next word issued at once waits five cycles. If it is issued after the reload has finished, it waits none.
- R6: A fetch of any address other than the next expected word is a branch and causes a reload. This includes a word that is already in the buffer.
- R7: A fetch to a different group issued while an automatic reload is running waits for that reload to finish and then for its own reload: eleven wait states in total.
- R8: With `pf_enable` low, every fetch takes five wait states and leaves the buffer invalid. The first fetch after re-enabling misses.
- R9: With `fetch_req` low, `fetch_wait` is low and `fetch_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_enable | input | 1 | 1 turns buffering on, 0 sends every fetch to flash |
| fetch_req | input | 1 | Fetch request, held until `fetch_wait` is low |
| fetch_addr | input | 20 | Byte address of the fetch |
| fetch_wait | output | 1 | Wait state to the core |
| fetch_data | output | 32 | Fetched word, valid when request is high and wait is low |
| flash_rd | output | 1 | Flash read strobe, high for each cycle of an access |
| flash_addr | output | 108 | Six 18-bit word addresses, one per bank |
| flash_rdata | input | 192 | Six 32-bit words, one per bank |

## Verification
The fetch stream mixes several patterns. An aligned sequential run across group borders shows the zero-wait hits apart from the automatic reload. A sequential run with idle cycles after a group end shows that the automatic reload finished in the background. Forward and backward branches, one of them to a word still held in the buffer, show that only the exact next word counts as a hit. A branch issued during an automatic reload and a run with buffering disabled and then re-enabled each produce a wait count that no other path gives. The bench flash returns garbage unless the six addresses have been steady for six cycles, so any early capture or address drift shows up as a data mismatch.

// File: rtl/ipf_pkg.sv
package ipf_pkg;

    localparam int ADDR_W       = 20;
    localparam int DATA_W       = 32;
    localparam int N_BANKS      = 6;
    localparam int FLASH_CYCLES = 6;

    localparam int BYTE_OFF_W = $clog2(DATA_W / 8);
    localparam int WADDR_W    = ADDR_W - BYTE_OFF_W;
    localparam int N_GROUPS   = ((1 << WADDR_W) + N_BANKS - 1) / N_BANKS;
    localparam int GRP_W      = $clog2(N_GROUPS);
    localparam int OFF_W      = $clog2(N_BANKS);
    localparam int LINE_W     = N_BANKS * DATA_W;

    typedef logic [WADDR_W-1:0] waddr_t;
    typedef logic [GRP_W-1:0]   grp_t;
    typedef logic [OFF_W-1:0]   off_t;
    typedef logic [DATA_W-1:0]  data_t;

    localparam grp_t LAST_GRP = grp_t'(N_GROUPS - 1);

    typedef enum logic {SEQ_IDLE, SEQ_FILL} seq_state_e;

    function automatic grp_t grp_of(input waddr_t w);
        waddr_t q;
        q = w / waddr_t'(N_BANKS);
        return grp_t'(q);
    endfunction

    function automatic waddr_t base_of(input grp_t g);
        return waddr_t'(g) * waddr_t'(N_BANKS);
    endfunction

    function automatic off_t off_of(input waddr_t w);
        waddr_t d;
        d = w - base_of(grp_of(w));
        return off_t'(d);
    endfunction

    function automatic grp_t next_grp(input grp_t g);
        return (g == LAST_GRP) ? '0 : g + grp_t'(1);
    endfunction

endpackage

// File: rtl/ipf_line_store.sv
module ipf_line_store
    import ipf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LINE_W-1:0] line_in,
    input  logic              sel_fill,
    input  off_t              sel,
    output data_t             word_out
);

    data_t bank_q [N_BANKS];
    data_t fill_w [N_BANKS];

    generate
        for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
            assign fill_w[b] = line_in[b*DATA_W +: DATA_W];
            always_ff @(posedge clk) begin
                if (rst) begin
                    bank_q[b] <= '0;
                end else if (load) begin
                    bank_q[b] <= fill_w[b];
                end
            end
        end
    endgenerate

    always_comb begin
        word_out = '0;
        for (int i = 0; i < N_BANKS; i++) begin
            if (sel == off_t'(i)) begin
                word_out = sel_fill ? fill_w[i] : bank_q[i];
            end
        end
    end

endmodule

// File: rtl/ipf_tracker.sv
module ipf_tracker
    import ipf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  waddr_t fetch_word,
    input  logic   miss_start,
    input  logic   hit_take,
    input  logic   fill_done,
    input  logic   deliver,
    output logic   hit,
    output logic   same_grp,
    output logic   chain,
    output grp_t   fetch_grp,
    output off_t   fetch_off,
    output grp_t   grp_q
);

    logic   valid_q;
    off_t   ptr_q;
    waddr_t exp_word;
    logic   last_taken;

    assign fetch_grp  = grp_of(fetch_word);
    assign fetch_off  = off_of(fetch_word);
    assign exp_word   = base_of(grp_q) + waddr_t'(ptr_q);
    assign hit        = en && valid_q && (fetch_word == exp_word);
    assign same_grp   = (fetch_grp == grp_q);
    assign last_taken = (hit_take && ptr_q == off_t'(N_BANKS-1)) ||
                        (deliver && fetch_off == off_t'(N_BANKS-1));
    assign chain      = en && last_taken;

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q   <= '0;
            ptr_q   <= '0;
            valid_q <= 1'b0;
        end else if (miss_start) begin
            grp_q   <= fetch_grp;
            ptr_q   <= '0;
            valid_q <= 1'b0;
        end else if (chain) begin
            grp_q   <= next_grp(grp_q);
            ptr_q   <= '0;
            valid_q <= 1'b0;
        end else if (fill_done) begin
            valid_q <= en;
            if (deliver && fetch_off != off_t'(N_BANKS-1)) begin
                ptr_q <= fetch_off + off_t'(1);
            end else begin
                ptr_q <= '0;
            end
        end else if (hit_take) begin
            ptr_q <= ptr_q + off_t'(1);
        end
    end

    // R4
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_q < off_t'(N_BANKS));

    // R8
    bypass_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_done && !en) |=> !valid_q);

    // R1
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_q) |-> $past(fill_done));

endmodule

// File: rtl/ipf_seq.sv
module ipf_seq
    import ipf_pkg::*;
#(
    parameter int LAT = FLASH_CYCLES
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic hit,
    input  logic same_grp,
    input  logic chain,
    output logic in_fill,
    output logic flash_rd,
    output logic core_wait,
    output logic miss_start,
    output logic hit_take,
    output logic fill_done,
    output logic deliver
);

    localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;
    typedef logic [CNT_W-1:0] cnt_t;
    localparam cnt_t LAST = cnt_t'(LAT - 1);

    seq_state_e state_q, state_d;
    cnt_t       cnt_q, cnt_d;

    assign in_fill = (state_q == SEQ_FILL);

    always_comb begin
        hit_take   = 1'b0;
        miss_start = 1'b0;
        fill_done  = 1'b0;
        deliver    = 1'b0;
        flash_rd   = 1'b0;
        core_wait  = 1'b0;
        if (state_q == SEQ_IDLE) begin
            hit_take   = req && hit;
            miss_start = req && !hit;
            flash_rd   = miss_start;
            core_wait  = miss_start;
        end else begin
            fill_done  = (cnt_q == LAST);
            deliver    = fill_done && req && same_grp;
            flash_rd   = 1'b1;
            core_wait  = req && !deliver;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (state_q == SEQ_IDLE) begin
            if (miss_start) begin
                state_d = SEQ_FILL;
                cnt_d   = cnt_t'(1);
            end else if (hit_take && chain) begin
                state_d = SEQ_FILL;
                cnt_d   = '0;
            end
        end else if (fill_done) begin
            cnt_d = '0;
            if (!chain) begin
                state_d = SEQ_IDLE;
            end
        end else begin
            cnt_d = cnt_q + cnt_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // R9
    idle_wait_chk: assert property (@(posedge clk) disable iff (rst)
        !req |-> !core_wait);

    // R3
    flash_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flash_rd && !fill_done) |=> flash_rd);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/ifetch_prefetch_buf.sv
module ifetch_prefetch_buf
    import ipf_pkg::*;
#(
    parameter int FLASH_LAT = FLASH_CYCLES
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pf_enable,
    input  logic                       fetch_req,
    input  logic [ADDR_W-1:0]          fetch_addr,
    output logic                       fetch_wait,
    output logic [DATA_W-1:0]          fetch_data,
    output logic                       flash_rd,
    output logic [N_BANKS*WADDR_W-1:0] flash_addr,
    input  logic [LINE_W-1:0]          flash_rdata
);

    localparam int WR_W = $clog2(2*FLASH_LAT + 1) + 1;

    waddr_t fetch_word;
    logic   hit, same_grp, chain;
    logic   in_fill, miss_start, hit_take, fill_done, deliver;
    grp_t   fetch_grp, grp_q, flash_grp;
    off_t   fetch_off;
    data_t  sel_word;

    assign fetch_word = fetch_addr[ADDR_W-1:BYTE_OFF_W];

    ipf_tracker u_track (
        .clk        (clk),
        .rst        (rst),
        .en         (pf_enable),
        .fetch_word (fetch_word),
        .miss_start (miss_start),
        .hit_take   (hit_take),
        .fill_done  (fill_done),
        .deliver    (deliver),
        .hit        (hit),
        .same_grp   (same_grp),
        .chain      (chain),
        .fetch_grp  (fetch_grp),
        .fetch_off  (fetch_off),
        .grp_q      (grp_q)
    );

    ipf_seq #(.LAT(FLASH_LAT)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req        (fetch_req),
        .hit        (hit),
        .same_grp   (same_grp),
        .chain      (chain),
        .in_fill    (in_fill),
        .flash_rd   (flash_rd),
        .core_wait  (fetch_wait),
        .miss_start (miss_start),
        .hit_take   (hit_take),
        .fill_done  (fill_done),
        .deliver    (deliver)
    );

    ipf_line_store u_store (
        .clk      (clk),
        .rst      (rst),
        .load     (fill_done),
        .line_in  (flash_rdata),
        .sel_fill (in_fill),
        .sel      (fetch_off),
        .word_out (sel_word)
    );

    assign flash_grp  = in_fill ? grp_q : fetch_grp;
    assign fetch_data = (fetch_req && !fetch_wait) ? sel_word : '0;

    generate
        for (genvar b = 0; b < N_BANKS; b++) begin : g_faddr
            assign flash_addr[b*WADDR_W +: WADDR_W] = base_of(flash_grp) + waddr_t'(b);
        end
    endgenerate

    logic [WR_W-1:0] wait_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            wait_run <= '0;
        end else if (!fetch_wait) begin
            wait_run <= '0;
        end else if (wait_run != '1) begin
            wait_run <= wait_run + WR_W'(1);
        end
    end

    // R7
    wait_len_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_wait |-> (wait_run < WR_W'(2*FLASH_LAT - 1)));

    // R3
    flash_grp_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (in_fill && $past(in_fill) && !$past(fill_done)) |-> $stable(flash_grp));

endmodule

// File: tb/ifetch_prefetch_buf_test.sv
module ifetch_prefetch_buf_test;
    import ipf_pkg::*;

    localparam int LAT = FLASH_CYCLES;
    localparam int W   = LAT - 1;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       pf_enable = 1'b0;
    logic                       fetch_req = 1'b0;
    logic [ADDR_W-1:0]          fetch_addr = '0;
    logic                       fetch_wait;
    logic [DATA_W-1:0]          fetch_data;
    logic                       flash_rd;
    logic [N_BANKS*WADDR_W-1:0] flash_addr;
    logic [LINE_W-1:0]          flash_rdata;

    always #4 clk = ~clk;

    ifetch_prefetch_buf uut (
        .clk         (clk),
        .rst         (rst),
        .pf_enable   (pf_enable),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .fetch_wait  (fetch_wait),
        .fetch_data  (fetch_data),
        .flash_rd    (flash_rd),
        .flash_addr  (flash_addr),
        .flash_rdata (flash_rdata)
    );

    function automatic data_t flash_word(input waddr_t w);
        return (32'(w) * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    // Flash model: data is only good once the addresses have been steady for LAT cycles
    logic [N_BANKS*WADDR_W-1:0] prev_addr;
    int                         stable;
    always @(posedge clk) begin
        if (rst) begin
            stable    <= 0;
            prev_addr <= '0;
        end else if (flash_rd) begin
            stable    <= (flash_addr == prev_addr) ? stable + 1 : 1;
            prev_addr <= flash_addr;
        end else begin
            stable <= 0;
        end
    end

    always_comb begin
        for (int b = 0; b < N_BANKS; b++) begin
            if (flash_rd && stable >= LAT - 1 && flash_addr == prev_addr)
                flash_rdata[b*DATA_W +: DATA_W] = flash_word(flash_addr[b*WADDR_W +: WADDR_W]);
            else
                flash_rdata[b*DATA_W +: DATA_W] = 32'hDEADBEEF;
        end
    end

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    typedef struct {
        logic [ADDR_W-1:0] addr;
        data_t             data;
        int                waits;
        string             tag;
    } exp_t;

    exp_t sb_q[$];
    int   wcnt = 0;

    // Monitor: counts wait cycles and compares each completion with the scoreboard
    always @(negedge clk) begin
        if (!rst && flash_rd) begin
            logic [WADDR_W-1:0] b0;
            bit ok;
            b0 = flash_addr[0 +: WADDR_W];
            ok = (b0 % N_BANKS) == 0;
            for (int i = 1; i < N_BANKS; i++)
                ok = ok && (flash_addr[i*WADDR_W +: WADDR_W] == b0 + WADDR_W'(i));
            check(ok, "R3", "bank addresses", 64'(flash_addr[2*WADDR_W-1:0]), 64'(b0));
        end
        if (!rst && fetch_req) begin
            if (fetch_wait) begin
                wcnt++;
            end else begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected completion", 64'(fetch_addr), 64'(0));
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(fetch_data == e.data, e.tag, "data", 64'(fetch_data), 64'(e.data));
                    check(wcnt == e.waits, e.tag, "wait states", 64'(wcnt), 64'(e.waits));
                end
                wcnt = 0;
            end
        end
    end

    // Driver: queue the expected item, then hold the request until wait drops
    task automatic fetch(input int w, input int waits, input string tag, input int lowbits = 0);
        exp_t e;
        e.addr  = ADDR_W'(w*4 + lowbits);
        e.data  = flash_word(WADDR_W'(w));
        e.waits = waits;
        e.tag   = tag;
        sb_q.push_back(e);
        @(posedge clk); #1;
        fetch_req  = 1'b1;
        fetch_addr = e.addr;
        do @(negedge clk); while (fetch_wait);
    endtask

    task automatic idle(input int n);
        @(posedge clk); #1;
        fetch_req = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(!fetch_wait && fetch_data == '0, "R9", "idle outputs",
                  {31'b0, fetch_wait, fetch_data}, 64'(0));
            if (i < n - 1) @(posedge clk);
        end
    endtask

    task automatic set_enable(input bit v);
        @(posedge clk); #1;
        pf_enable = v;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!fetch_wait, "R1", "wait after reset", 64'(fetch_wait), 64'(0));
        check(!flash_rd, "R1", "flash_rd after reset", 64'(flash_rd), 64'(0));
        check(fetch_data == '0, "R9", "data after reset", 64'(fetch_data), 64'(0));
        set_enable(1'b1);

        fetch(0, W, "R1");
        fetch(1, 0, "R4");
        fetch(2, 0, "R4");
        fetch(3, 0, "R4", 2);
        fetch(4, 0, "R4");
        fetch(5, 0, "R4");
        fetch(6, W, "R5");
        for (int w = 7; w < 12; w++) fetch(w, 0, "R4");
        idle(12);
        check(!flash_rd, "R5", "background reload finished", 64'(flash_rd), 64'(0));
        fetch(12, 0, "R5");
        fetch(13, 0, "R4", 3);
        fetch(40, W, "R6");
        fetch(41, 0, "R4");
        fetch(42, W, "R5");
        fetch(43, 0, "R4");
        fetch(42, W, "R6");
        for (int w = 43; w < 48; w++) fetch(w, 0, "R4");
        fetch(100, 2*LAT - 1, "R7");
        fetch(101, 0, "R4");
        idle(10);
        set_enable(1'b0);
        fetch(198, W, "R8");
        fetch(199, W, "R8");
        fetch(200, W, "R8");
        idle(2);
        set_enable(1'b1);
        fetch(201, W, "R8");
        fetch(202, 0, "R4");
        fetch(203, 0, "R4");
        fetch(204, W, "R5");
        idle(3);
        check(sb_q.size() == 0, "R2", "scoreboard drained", 64'(sb_q.size()), 64'(0));
        done = 1'b1;
        report();
        $finish;
    end

endmodule